// File: doc/BRIEF.md
# Multi-Channel Down-Counting Event Timer

This block is a register-mapped timer bank with a parameterised number of independent channels. Each channel keeps a live down-count and a separate reload value. It advances by one step on each rising edge of a slow time-base input that its control register selects. When the count runs down to zero, the channel raises a sticky event flag. In one-shot use the channel then stops, and it rearms when a new reload value is written. In repeating use it reloads and keeps running. Loading all ones into the reload value gives a full-range free-running counter, which software can read as an elapsed-time source.

Software reaches the block through a single-cycle, word-addressed register port. Writes take effect at the next clock edge and reads are combinational. Each writable register also answers at two alias addresses, one that sets bits and one that clears bits, so that single bits can be changed without a read-modify-write. Each channel drives one interrupt line. A read-only identity register reports the block's major revision, and a global control word can return every channel to its reset state.

Top module: `tick_timer_bank`

## Requirements
- R1: After rst_n low, or after a write with bit 31 set to the global word at address 0x00 (or its set alias at 0x04), every channel's control word, live count and reload value read zero and every irq line is low from the next cycle on.
- R2: The word at address 0x20 + NCH*0x40 reads 0x0200_0000, with major revision 2 in bits [31:23+1].
- R3: Channel n has its control word at 0x20+n*0x40, its read-only live count at 0x30+n*0x40 and its reload value at 0x40+n*0x40. Only control bits [3:0] (source select), 6 (repeat), 7 (immediate load), 14 (interrupt enable) and 15 (event flag) are stored, and all other control bits read zero.
- R4: A write to register address +0x4 ORs the ones in the data into the register, and a write to +0x8 clears them. All other bits are left unchanged. A write whose low two address bits are not zero is ignored.
- R5: A select value k in 1..NSRC makes the channel step once per rising edge of src_clk[k-1], after two synchroniser stages and an edge detector. Edges on other inputs, or any edge when the select is 0, leave the count unchanged. Channels step independently.
- R6: A reload write while the count is zero loads the new value at the next step. Each later step decrements the count. The step that takes the count from 1 to 0 sets the event flag, and with the repeat bit clear the count then stays at zero.
- R7: With the repeat bit set, a step taken while the count is zero loads the reload value, giving a period of reload+1 steps.
- R8: With the immediate-load bit set, a reload write replaces the count at the next step. With the bit clear and the count non-zero, the count keeps decrementing and the new value is used only at the next reload.
- R9: irq[n] is high exactly while channel n's event flag and interrupt enable are both set. The flag latches whether or not the enable is set, and it stays set until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_clk | input | NSRC | Slow time-base inputs, asynchronous to clk |
| bus_we | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NCH | Per-channel interrupt lines |

## Verification
On every cycle, the assertions in the channel check the stepping rules. With no step the count holds. A normal step decrements the count, and a step at zero either reloads or holds according to the repeat bit. A step from 1 sets the flag. The assertions also check that a synchronised step pulse never lasts two cycles and that a soft reset drops every interrupt. The address map, the alias bit arithmetic, source selection, the deferred and immediate load choice and the interrupt masking can only be shown by the bench's scenarios. These scenarios sweep one-shot delays and repeating periods and compare each count against values worked out arithmetically.

// File: rtl/tmr_pkg.sv
// Shared constants and helpers for the timer bank.
// Assumes 32-bit register words and a 4-bit source select field.
package tmr_pkg;
    localparam int SEL_W    = 4;
    localparam int RPT_B    = 6;
    localparam int IMM_B    = 7;
    localparam int IEN_B    = 14;
    localparam int FLAG_B   = 15;
    localparam logic [31:0] CTRL_MASK = 32'h0000_C0CF;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_SET = 2'd1;
    localparam logic [1:0] OP_CLR = 2'd2;

    // Combine an old register value with write data under an alias op.
    function automatic logic [31:0] merge_op(input logic [31:0] old_v,
                                             input logic [31:0] d,
                                             input logic [1:0]  op);
        case (op)
            OP_SET:  return old_v | d;
            OP_CLR:  return old_v & ~d;
            default: return d;
        endcase
    endfunction
endpackage

// File: rtl/tmr_src_sync.sv
// Synchronises N asynchronous time-base inputs into clk and emits a
// one-cycle pulse per rising edge. Assumes each input stays high and low
// for at least two clk cycles.
module tmr_src_sync #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    output logic [N-1:0] pulse
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic s1_q, s2_q, s3_q;

        // Two-flop synchroniser plus one history stage for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
                s3_q <= 1'b0;
            end else begin
                s1_q <= src[i];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end

        assign pulse[i] = s2_q & ~s3_q;

        // R5
        single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[i] |=> !pulse[i]);
    end
endmodule

// File: rtl/tmr_channel.sv
// One timer channel: control word, reload value and live down-count.
// Assumes tick is a single-cycle step enable; CW must not exceed 32.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst,
    input  logic          tick,
    input  logic          ctrl_we,
    input  logic          fix_we,
    input  logic [1:0]    op,
    input  logic [31:0]   wdata,
    output logic [31:0]   ctrl_q,
    output logic [CW-1:0] count_q,
    output logic [CW-1:0] fixed_q,
    output logic          irq
);
    logic        pend_q;
    logic [31:0] fix_next;
    logic        at_zero;
    logic        fire;

    assign fix_next = merge_op(32'(fixed_q), wdata, op);
    assign at_zero  = (count_q == '0);
    assign fire     = tick && !pend_q && (count_q == CW'(1));
    assign irq      = ctrl_q[FLAG_B] & ctrl_q[IEN_B];

    // Control word: software updates, with the hardware event setting the flag.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            ctrl_q <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= merge_op(ctrl_q, wdata, op) & CTRL_MASK;
            if (fire)    ctrl_q[FLAG_B] <= 1'b1;
        end
    end

    // Reload value and the pending-load request it raises.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            fixed_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (tick && pend_q) pend_q <= 1'b0;
            if (fix_we) begin
                fixed_q <= fix_next[CW-1:0];
                pend_q  <= ctrl_q[IMM_B] || at_zero;
            end
        end
    end

    // Live count: load, decrement, reload or hold, once per step.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            count_q <= '0;
        end else if (tick) begin
            if (pend_q)              count_q <= fixed_q;
            else if (!at_zero)       count_q <= count_q - 1'b1;
            else if (ctrl_q[RPT_B])  count_q <= fixed_q;
        end
    end

    // R5
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
        !tick |=> $stable(count_q));
    // R6
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
        tick && !pend_q && count_q != '0 |=> count_q == $past(count_q) - 1'b1);
    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
        tick && !pend_q && count_q == '0 && !ctrl_q[RPT_B] |=> count_q == '0);
    // R7
    repeat_load_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
        tick && !pend_q && count_q == '0 && ctrl_q[RPT_B] |=> count_q == $past(fixed_q));
    // R6
    flag_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
        tick && !pend_q && count_q == CW'(1) |=> ctrl_q[FLAG_B]);
endmodule

// File: rtl/tick_timer_bank.sv
// Timer bank top: register decode with set/clear aliases, read mux,
// identity word, global soft reset and per-channel source selection.
// Assumes NSRC <= 15 and that AW covers the identity word address.
module tick_timer_bank
    import tmr_pkg::*;
#(
    parameter int          NCH       = 2,
    parameter int          NSRC      = 11,
    parameter int          CW        = 32,
    parameter int          AW        = 8,
    parameter logic [7:0]  VER_MAJOR = 8'h02
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_clk,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic [NCH-1:0]  irq
);
    localparam int          BASE     = 32;
    localparam int          STRIDE   = 64;
    localparam logic [AW-1:0] VER_ADDR = AW'(BASE + NCH * STRIDE);
    localparam logic [31:0] VER_WORD = {VER_MAJOR, 24'h0};

    logic [1:0]      op;
    logic            wr_ok;
    logic            soft_rst;
    logic [NSRC-1:0] src_pulse;
    logic [15:0]     tick_pad;

    logic [31:0]   ctrl_q  [NCH];
    logic [CW-1:0] count_q [NCH];
    logic [CW-1:0] fixed_q [NCH];

    assign op       = bus_addr[3:2];
    assign wr_ok    = bus_we && (op != 2'd3) && (bus_addr[1:0] == 2'b00);
    assign soft_rst = wr_ok && (bus_addr[AW-1:4] == '0) && (op != OP_CLR) && bus_wdata[31];
    assign tick_pad = 16'({src_pulse, 1'b0});

    tmr_src_sync #(.N(NSRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (src_clk),
        .pulse (src_pulse)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        localparam logic [AW-1:0] CB = AW'(BASE + n * STRIDE);
        localparam logic [AW-1:0] FB = AW'(BASE + n * STRIDE + 32);
        logic ctrl_hit, fix_hit;

        assign ctrl_hit = bus_addr[AW-1:4] == CB[AW-1:4];
        assign fix_hit  = bus_addr[AW-1:4] == FB[AW-1:4];

        tmr_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .srst    (soft_rst),
            .tick    (tick_pad[ctrl_q[n][SEL_W-1:0]]),
            .ctrl_we (wr_ok && ctrl_hit),
            .fix_we  (wr_ok && fix_hit),
            .op      (op),
            .wdata   (bus_wdata),
            .ctrl_q  (ctrl_q[n]),
            .count_q (count_q[n]),
            .fixed_q (fixed_q[n]),
            .irq     (irq[n])
        );
    end

    // Read mux: identity word, then per-channel control, count and reload.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[AW-1:4] == VER_ADDR[AW-1:4]) bus_rdata = VER_WORD;
        for (int n = 0; n < NCH; n++) begin
            if (bus_addr[AW-1:4] == 4'(((BASE + n * STRIDE) >> 4)))      bus_rdata = ctrl_q[n];
            if (bus_addr[AW-1:4] == 4'(((BASE + n * STRIDE + 16) >> 4))) bus_rdata = 32'(count_q[n]);
            if (bus_addr[AW-1:4] == 4'(((BASE + n * STRIDE + 32) >> 4))) bus_rdata = 32'(fixed_q[n]);
        end
    end

    // R1
    soft_rst_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> irq == '0);
endmodule

// File: tb/tick_timer_bank_tb.sv
module tick_timer_bank_tb;
    localparam int NCH = 2, NSRC = 11, AW = 8;
    localparam logic [7:0] CTRL0 = 8'h20, RUN0 = 8'h30, FIX0 = 8'h40;
    localparam logic [7:0] CTRL1 = 8'h60, RUN1 = 8'h70, FIX1 = 8'h80, VER = 8'hA0;

    logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
    logic [NSRC-1:0] src_clk = '0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NCH-1:0] irq;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tick_timer_bank #(.NCH(NCH), .NSRC(NSRC), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_clk(src_clk), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0; #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic tick(input int i);
        @(negedge clk); src_clk[i] = 1'b1;
        repeat (4) @(negedge clk);
        src_clk[i] = 1'b0;
        repeat (4) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        rd(CTRL0, v); chk("R1 ctrl0 reset", v, 0);
        rd(RUN0, v);  chk("R1 count0 reset", v, 0);
        rd(FIX1, v);  chk("R1 reload1 reset", v, 0);
        chk("R1 irq reset", 32'(irq), 0);
        // R2 identity word
        rd(VER, v); chk("R2 version", v, 32'h0200_0000);

        // R6 one-shot sweep over delays 1..5 on source 0xB
        wr(CTRL0, 32'h0000_000B);
        for (int n = 1; n <= 5; n++) begin
            wr(FIX0, n);
            for (int k = 1; k <= n + 2; k++) begin
                tick(10);
                rd(RUN0, v);  chk("R6 one-shot count", v, (n + 1 - k > 0) ? n + 1 - k : 0);
                rd(CTRL0, v); chk("R6 flag", 32'(v[15]), (k >= n + 1) ? 1 : 0);
                chk("R9 masked irq", 32'(irq[0]), 0);
            end
            wr(CTRL0 + 8'h8, 32'h0000_8000);
            rd(CTRL0, v); chk("R4 clear alias keeps others", v, 32'h0000_000B);
        end

        // R5 select 0 holds, set alias selects source, other sources ignored
        wr(CTRL0, 32'h0);
        wr(FIX0, 7);
        tick(10); tick(10);
        rd(RUN0, v); chk("R5 select zero holds", v, 0);
        wr(CTRL0 + 8'h4, 32'h0000_000B);
        tick(10);
        rd(RUN0, v); chk("R5 selected source steps", v, 7);
        tick(0);
        rd(RUN0, v); chk("R5 other source ignored", v, 7);
        wr(CTRL1, 32'h0000_0001);
        wr(FIX1, 4);
        tick(0);
        rd(RUN1, v); chk("R5 channel1 independent", v, 4);
        rd(RUN0, v); chk("R5 channel0 untouched", v, 7);

        // R8 deferred vs immediate load
        wr(FIX0, 20);
        tick(10);
        rd(RUN0, v); chk("R8 deferred load", v, 6);
        wr(CTRL0 + 8'h4, 32'h0000_0080);
        wr(FIX0, 9);
        tick(10);
        rd(RUN0, v); chk("R8 immediate load", v, 9);
        tick(10);
        rd(RUN0, v); chk("R8 after load", v, 8);

        // R7 repeating with reload 3, starting from 8
        wr(CTRL0, 32'h0000_004B);
        wr(FIX0, 3);
        for (int k = 1; k <= 16; k++) begin
            tick(10);
            rd(RUN0, v);
            chk("R7 repeat count", v, (k <= 8) ? 8 - k : 3 - ((k - 9) % 4));
        end

        // R9 masking and clearing
        rd(CTRL0, v); chk("R9 flag latched while masked", 32'(v[15]), 1);
        chk("R9 irq low while masked", 32'(irq[0]), 0);
        wr(CTRL0 + 8'h4, 32'h0000_4000);
        chk("R9 irq with enable", 32'(irq[0]), 1);
        wr(CTRL0 + 8'h8, 32'h0000_8000);
        chk("R9 irq after clear", 32'(irq[0]), 0);
        rd(CTRL0, v); chk("R4 set and clear aliases", v, 32'h0000_404B);
        wr(CTRL0 + 8'h1, 32'h0000_8000);
        chk("R4 misaligned ignored", 32'(irq[0]), 0);

        // R3 stored control bits
        wr(CTRL1, 32'hFFFF_FFFF);
        rd(CTRL1, v); chk("R3 control mask", v, 32'h0000_C0CF);
        chk("R3 irq1 from flag and enable", 32'(irq[1]), 1);

        // R1 soft reset
        wr(8'h00, 32'h8000_0000);
        chk("R1 soft reset irq", 32'(irq), 0);
        rd(CTRL1, v); chk("R1 soft reset ctrl1", v, 0);
        rd(FIX0, v);  chk("R1 soft reset reload0", v, 0);
        rd(RUN1, v);  chk("R1 soft reset count1", v, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule